// File: doc/BRIEF.md
# Spike Event Link Controller

This block carries spike events between two neighbouring devices over a pair of one-way word links. On the local side, neurons hand over spike events one at a time as a neuron address. The controller tags each event with the current time-step number, forms a 32-bit link word and queues it in a clock-crossing FIFO. The link side then sends the word with a valid/ready handshake and an end-of-packet flag. Nothing is sent unless a local neuron has fired. A pulse on the step-end pin closes the current time step. The last word of that step carries the end-of-packet flag, and the step tag advances even if the step had no spikes.

The receive direction mirrors this path. Words with their end-of-packet flag arrive from the link in the link clock domain and cross a second, independent FIFO into the local clock domain. There they are split back into address and tag and offered to the local network on a valid/ready stream. Consuming a word that carries the end-of-packet flag raises a one-cycle step-complete strobe.

All three streams follow the same valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. A source holding valid high without ready keeps its payload unchanged. A full buffer deasserts ready, so no event is ever dropped.

Top module: `spike_link_ctrl`

## Requirements
- R1: A link word holds the neuron address in bits [ADDR_W-1:0] and the time-step tag in bits [31:ADDR_W]. The tag is 0 after reset and advances by one at every step-end pulse, including pulses that close a step with no spikes.
- R2: End-of-packet is set only on the last word of a time step. A step with a single spike yields one word with end-of-packet set.
- R3: A time step with no spikes produces no link word.
- R4: Spike events arrive at the local output in the order they were accepted, with none lost. While the output is valid and not ready, its address and tag hold steady.
- R5: With the outgoing link stalled, exactly DEPTH+1 spikes are accepted (DEPTH in the FIFO, one held back for packet closing). After that, spk_in_ready stays low and no FIFO write happens while the FIFO is full.
- R6: While lnk_tx_valid is high and lnk_tx_ready is low, lnk_tx_data and lnk_tx_eop do not change.
- R7: With the local output stalled and the link looped back, the controller absorbs exactly 2*DEPTH+1 spikes. After that, lnk_rx_ready is low.
- R8: step_done pulses for one local cycle, exactly one cycle after the local output hands over a word whose end-of-packet flag is set. It never pulses at any other time.
- R9: After reset, spk_in_ready is 1 and spk_out_valid, lnk_tx_valid and step_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_loc | input | 1 | Local network clock |
| rst_loc_n | input | 1 | Local domain reset, active low, asynchronous |
| clk_lnk | input | 1 | Link clock |
| rst_lnk_n | input | 1 | Link domain reset, active low, asynchronous |
| spk_in_valid | input | 1 | Local spike event offered |
| spk_in_ready | output | 1 | Controller accepts the spike event |
| spk_in_addr | input | ADDR_W | Address of the firing neuron |
| step_end | input | 1 | Pulse that closes the current time step |
| lnk_tx_valid | output | 1 | Outgoing link word valid |
| lnk_tx_ready | input | 1 | Far side accepts the outgoing word |
| lnk_tx_data | output | 32 | Outgoing link word |
| lnk_tx_eop | output | 1 | Outgoing word is the last of its step |
| lnk_rx_valid | input | 1 | Incoming link word valid |
| lnk_rx_ready | output | 1 | Controller accepts the incoming word |
| lnk_rx_data | input | 32 | Incoming link word |
| lnk_rx_eop | input | 1 | Incoming word is the last of its step |
| spk_out_valid | output | 1 | Received spike event valid |
| spk_out_ready | input | 1 | Local network takes the event |
| spk_out_addr | output | ADDR_W | Received neuron address |
| spk_out_tag | output | 32-ADDR_W | Received time-step tag |
| step_done | output | 1 | One-cycle strobe after a step's last word is taken |

## Verification
Several properties are checked on every clock edge in both domains:
- The outgoing and received streams hold their payload while stalled.
- The transmit FIFO is never written while full, and a full FIFO always shows as deasserted spike-input ready.
- Every step-complete strobe follows a local handover.

Other behaviour can only be shown by the bench's scenarios, which run the controller in loopback:
- Word layout and tag counting across empty steps.
- End-of-packet placement.
- Ordering without loss.
- The exact event counts absorbed under each stall.

// File: rtl/spk_link_pkg.sv
package spk_link_pkg;

  localparam int WORD_W = 32;

  function automatic logic [7:0] bin2gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] gray2bin(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/spk_gray_sync.sv
module spk_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spk_async_fifo.sv
module spk_async_fifo
  import spk_link_pkg::*;
#(
  parameter int W     = 33,
  parameter int DEPTH = 8
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic [7:0]    wgray_wide, rgray_wide;

  assign wbin_nx    = wbin + PW'(1);
  assign rbin_nx    = rbin + PW'(1);
  assign wgray_wide = bin2gray(8'(wbin_nx));
  assign rgray_wide = bin2gray(8'(rbin_nx));

  // write domain
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en && !full) begin
      wbin  <= wbin_nx;
      wgray <= wgray_wide[PW-1:0];
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  spk_gray_sync #(.W(PW)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );

  // full when the write pointer is one lap ahead of the synchronised read pointer
  assign full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  // read domain
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en && !empty) begin
      rbin  <= rbin_nx;
      rgray <= rgray_wide[PW-1:0];
    end
  end

  spk_gray_sync #(.W(PW)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );

  assign empty = (rgray == wgray_r);
  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/spk_packer.sv
module spk_packer #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              step_end,
  output logic              push,
  output logic [WORD_W:0]   push_word,
  input  logic              fifo_full
);
  localparam int TAG_W = WORD_W - ADDR_W;

  logic              held_v;
  logic [ADDR_W-1:0] held_addr;
  logic              close_pend;
  logic [TAG_W-1:0]  tag;
  logic              accept;
  logic              close_go;

  assign in_ready  = !fifo_full && !close_pend;
  assign accept    = in_valid && in_ready;
  // closing waits for space only if a held word must be written
  assign close_go  = close_pend && (!held_v || !fifo_full);
  assign push      = held_v && (accept || close_go);
  assign push_word = {close_go, tag, held_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v     <= 1'b0;
      held_addr  <= '0;
      close_pend <= 1'b0;
      tag        <= '0;
    end else begin
      if (accept) begin
        held_v    <= 1'b1;
        held_addr <= in_addr;
      end else if (close_go) begin
        held_v <= 1'b0;
      end
      if (close_go) begin
        close_pend <= 1'b0;
        tag        <= tag + TAG_W'(1);
      end else if (step_end) begin
        close_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spk_unpacker.sv
module spk_unpacker #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WORD_W:0]          rd_word,
  input  logic                     fifo_empty,
  output logic                     rd_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [WORD_W-ADDR_W-1:0] out_tag,
  output logic                     step_done
);
  assign out_valid = !fifo_empty;
  assign rd_en     = out_valid && out_ready;
  assign out_addr  = rd_word[ADDR_W-1:0];
  assign out_tag   = rd_word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_done <= 1'b0;
    else        step_done <= rd_en && rd_word[WORD_W];
  end
endmodule

// File: rtl/spike_link_ctrl.sv
module spike_link_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 8
) (
  input  logic                 clk_loc,
  input  logic                 rst_loc_n,
  input  logic                 clk_lnk,
  input  logic                 rst_lnk_n,
  input  logic                 spk_in_valid,
  output logic                 spk_in_ready,
  input  logic [ADDR_W-1:0]    spk_in_addr,
  input  logic                 step_end,
  output logic                 lnk_tx_valid,
  input  logic                 lnk_tx_ready,
  output logic [31:0]          lnk_tx_data,
  output logic                 lnk_tx_eop,
  input  logic                 lnk_rx_valid,
  output logic                 lnk_rx_ready,
  input  logic [31:0]          lnk_rx_data,
  input  logic                 lnk_rx_eop,
  output logic                 spk_out_valid,
  input  logic                 spk_out_ready,
  output logic [ADDR_W-1:0]    spk_out_addr,
  output logic [31-ADDR_W:0]   spk_out_tag,
  output logic                 step_done
);
  localparam int WORD_W = spk_link_pkg::WORD_W;
  localparam int FW     = WORD_W + 1;

  logic          tx_push, tx_full, tx_empty;
  logic [FW-1:0] tx_wword, tx_rword;
  logic          rx_full, rx_empty, rx_rd;
  logic [FW-1:0] rx_rword;

  spk_packer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk_loc), .rst_n(rst_loc_n),
    .in_valid(spk_in_valid), .in_ready(spk_in_ready), .in_addr(spk_in_addr),
    .step_end(step_end), .push(tx_push), .push_word(tx_wword),
    .fifo_full(tx_full)
  );

  spk_async_fifo #(.W(FW), .DEPTH(DEPTH)) u_tx (
    .wclk(clk_loc), .wrst_n(rst_loc_n), .wr_en(tx_push), .wdata(tx_wword),
    .full(tx_full),
    .rclk(clk_lnk), .rrst_n(rst_lnk_n), .rd_en(lnk_tx_ready),
    .rdata(tx_rword), .empty(tx_empty)
  );

  assign lnk_tx_valid = !tx_empty;
  assign lnk_tx_data  = tx_rword[WORD_W-1:0];
  assign lnk_tx_eop   = tx_rword[WORD_W];

  spk_async_fifo #(.W(FW), .DEPTH(DEPTH)) u_rx (
    .wclk(clk_lnk), .wrst_n(rst_lnk_n), .wr_en(lnk_rx_valid),
    .wdata({lnk_rx_eop, lnk_rx_data}), .full(rx_full),
    .rclk(clk_loc), .rrst_n(rst_loc_n), .rd_en(rx_rd),
    .rdata(rx_rword), .empty(rx_empty)
  );

  assign lnk_rx_ready = !rx_full;

  spk_unpacker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_unpack (
    .clk(clk_loc), .rst_n(rst_loc_n), .rd_word(rx_rword),
    .fifo_empty(rx_empty), .rd_en(rx_rd),
    .out_valid(spk_out_valid), .out_ready(spk_out_ready),
    .out_addr(spk_out_addr), .out_tag(spk_out_tag), .step_done(step_done)
  );
endmodule

module spike_link_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_loc,
  input logic              rst_loc_n,
  input logic              clk_lnk,
  input logic              rst_lnk_n,
  input logic              tx_push,
  input logic              tx_full,
  input logic              spk_in_ready,
  input logic              spk_out_valid,
  input logic              spk_out_ready,
  input logic [ADDR_W-1:0] spk_out_addr,
  input logic [31-ADDR_W:0] spk_out_tag,
  input logic              step_done,
  input logic              lnk_tx_valid,
  input logic              lnk_tx_ready,
  input logic [31:0]       lnk_tx_data,
  input logic              lnk_tx_eop
);
  p_no_overflow_r5: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    tx_push |-> !tx_full);

  p_full_stalls_r5: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    tx_full |-> !spk_in_ready);

  p_out_hold_r4: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    spk_out_valid && !spk_out_ready |=>
      spk_out_valid && $stable(spk_out_addr) && $stable(spk_out_tag));

  p_done_after_take_r8: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    step_done |-> $past(spk_out_valid && spk_out_ready));

  p_tx_hold_r6: assert property (@(posedge clk_lnk) disable iff (!rst_lnk_n)
    lnk_tx_valid && !lnk_tx_ready |=>
      lnk_tx_valid && $stable(lnk_tx_data) && $stable(lnk_tx_eop));
endmodule

bind spike_link_ctrl spike_link_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_loc(clk_loc), .rst_loc_n(rst_loc_n),
  .clk_lnk(clk_lnk), .rst_lnk_n(rst_lnk_n),
  .tx_push(tx_push), .tx_full(tx_full), .spk_in_ready(spk_in_ready),
  .spk_out_valid(spk_out_valid), .spk_out_ready(spk_out_ready),
  .spk_out_addr(spk_out_addr), .spk_out_tag(spk_out_tag),
  .step_done(step_done),
  .lnk_tx_valid(lnk_tx_valid), .lnk_tx_ready(lnk_tx_ready),
  .lnk_tx_data(lnk_tx_data), .lnk_tx_eop(lnk_tx_eop)
);

// File: tb/spike_link_ctrl_bench.sv
module spike_link_ctrl_bench;
  localparam int ADDR_W = 20;
  localparam int TAG_W  = 32 - ADDR_W;
  localparam int DEPTH  = 8;
  localparam int NVEC   = 16;
  // {stall_out, last_of_step, addr}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 20'h00011}, {1'b0, 1'b0, 20'h00012}, {1'b0, 1'b1, 20'h00013},
    {1'b0, 1'b1, 20'h00024},
    {1'b1, 1'b0, 20'h00035}, {1'b1, 1'b1, 20'h00036},
    {1'b0, 1'b0, 20'hFFFFF}, {1'b0, 1'b0, 20'h00000}, {1'b0, 1'b1, 20'h80001},
    {1'b1, 1'b0, 20'h00047}, {1'b0, 1'b0, 20'h00048}, {1'b1, 1'b0, 20'h00049},
    {1'b0, 1'b1, 20'h0004A},
    {1'b1, 1'b1, 20'h55555},
    {1'b0, 1'b0, 20'h0AAAA}, {1'b0, 1'b1, 20'h0BBBB}
  };

  logic clk_loc = 1'b0, clk_lnk = 1'b0;
  logic rst_loc_n = 1'b0, rst_lnk_n = 1'b0;
  logic spk_in_valid = 1'b0;
  logic [ADDR_W-1:0] spk_in_addr = '0;
  logic step_end = 1'b0;
  logic rx_hold = 1'b0, lnk_gate = 1'b1;
  logic spk_in_ready, lnk_tx_valid, lnk_tx_eop, lnk_rx_ready;
  logic [31:0] lnk_tx_data;
  logic spk_out_valid, step_done;
  logic [ADDR_W-1:0] spk_out_addr;
  logic [TAG_W-1:0] spk_out_tag;

  always #2 clk_loc = ~clk_loc;
  always #3 clk_lnk = ~clk_lnk;

  spike_link_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_spike_link_ctrl (
    .clk_loc(clk_loc), .rst_loc_n(rst_loc_n),
    .clk_lnk(clk_lnk), .rst_lnk_n(rst_lnk_n),
    .spk_in_valid(spk_in_valid), .spk_in_ready(spk_in_ready),
    .spk_in_addr(spk_in_addr), .step_end(step_end),
    .lnk_tx_valid(lnk_tx_valid), .lnk_tx_ready(lnk_rx_ready && lnk_gate),
    .lnk_tx_data(lnk_tx_data), .lnk_tx_eop(lnk_tx_eop),
    .lnk_rx_valid(lnk_tx_valid && lnk_gate), .lnk_rx_ready(lnk_rx_ready),
    .lnk_rx_data(lnk_tx_data), .lnk_rx_eop(lnk_tx_eop),
    .spk_out_valid(spk_out_valid), .spk_out_ready(!rx_hold),
    .spk_out_addr(spk_out_addr), .spk_out_tag(spk_out_tag),
    .step_done(step_done)
  );

  int total = 0, bad = 0;
  int widx = 0, ridx = 0;
  logic [ADDR_W-1:0] exp_addr [128];
  logic [TAG_W-1:0]  exp_tag  [128];
  logic              exp_eop  [128];
  logic [TAG_W-1:0]  cur_tag = '0;
  logic              step_has = 1'b0;
  logic              done_due = 1'b0;

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // receiver: compares every handed-over event against the model queue
  always @(negedge clk_loc) begin
    if (rst_loc_n) begin
      if (done_due || step_done)
        check(step_done == done_due, "R8 step_done timing", step_done, done_due);
      done_due = 1'b0;
      if (spk_out_valid && !rx_hold) begin
        if (ridx < widx) begin
          check(spk_out_addr == exp_addr[ridx], "R4 order/addr", spk_out_addr, exp_addr[ridx]);
          check(spk_out_tag == exp_tag[ridx], "R1 tag", spk_out_tag, exp_tag[ridx]);
          done_due = exp_eop[ridx];
        end else begin
          check(1'b0, "R3 unexpected word", spk_out_addr, 0);
        end
        ridx++;
      end
    end
  end

  task automatic try_send(input logic [ADDR_W-1:0] a, input int limit, output logic ok);
    int k = 0;
    @(negedge clk_loc);
    spk_in_valid = 1'b1;
    spk_in_addr  = a;
    while (!spk_in_ready && k < limit) begin
      @(negedge clk_loc);
      k++;
    end
    ok = spk_in_ready;
    if (ok) begin
      exp_addr[widx] = a;
      exp_tag[widx]  = cur_tag;
      exp_eop[widx]  = 1'b0;
      widx++;
      step_has = 1'b1;
      @(negedge clk_loc);
    end
    spk_in_valid = 1'b0;
  endtask

  task automatic close_step();
    int k = 0;
    if (step_has) exp_eop[widx-1] = 1'b1;
    step_has = 1'b0;
    cur_tag  = cur_tag + TAG_W'(1);
    @(negedge clk_loc);
    step_end = 1'b1;
    @(negedge clk_loc);
    step_end = 1'b0;
    while (!spk_in_ready && k < 2000) begin
      @(negedge clk_loc);
      k++;
    end
  endtask

  task automatic set_hold(input logic h);
    @(posedge clk_loc);
    #1 rx_hold = h;
  endtask

  task automatic drain();
    int k = 0;
    set_hold(1'b0);
    while (ridx < widx && k < 4000) begin
      @(negedge clk_loc);
      k++;
    end
    repeat (4) @(negedge clk_loc);
    check(ridx == widx, "R4 all delivered", ridx, widx);
  endtask

  int wd = 0;
  always @(posedge clk_loc) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok;
    int n;
    repeat (3) @(negedge clk_loc);
    // R9 reset state, sampled while reset is held
    check(spk_out_valid == 1'b0, "R9 out_valid", spk_out_valid, 0);
    check(lnk_tx_valid == 1'b0, "R9 tx_valid", lnk_tx_valid, 0);
    check(step_done == 1'b0, "R9 step_done", step_done, 0);
    rst_loc_n = 1'b1;
    rst_lnk_n = 1'b1;
    repeat (3) @(negedge clk_loc);
    check(spk_in_ready == 1'b1, "R9 in_ready", spk_in_ready, 1);

    // table walk: R1 R2 tags and end-of-packet, R4 with stalls
    for (int i = 0; i < NVEC; i++) begin
      set_hold(VEC[i][21]);
      try_send(VEC[i][19:0], 2000, ok);
      check(ok, "R4 table spike accepted", ok, 1);
      if (VEC[i][20]) close_step();
    end
    drain();

    // R3 empty step: no word, tag still advances (R1)
    n = ridx;
    close_step();
    repeat (40) @(negedge clk_loc);
    check(ridx == n && !spk_out_valid, "R3 empty step silent", ridx, n);
    try_send(20'h00777, 2000, ok);
    close_step();
    drain();

    // R5 link stalled: DEPTH+1 accepted
    lnk_gate = 1'b0;
    n = 0;
    ok = 1'b1;
    while (ok && n < 40) begin
      try_send(20'h00500 + 20'(n), 60, ok);
      if (ok) n++;
    end
    check(n == DEPTH + 1, "R5 accepted with link stalled", n, DEPTH + 1);
    check(spk_in_ready == 1'b0, "R5 ready low", spk_in_ready, 0);
    lnk_gate = 1'b1;
    close_step();
    drain();

    // R7 local output stalled, loopback open: 2*DEPTH+1 accepted
    set_hold(1'b1);
    n = 0;
    ok = 1'b1;
    while (ok && n < 60) begin
      try_send(20'h00900 + 20'(n), 80, ok);
      if (ok) n++;
    end
    check(n == 2 * DEPTH + 1, "R7 accepted with output stalled", n, 2 * DEPTH + 1);
    @(negedge clk_lnk);
    check(lnk_rx_ready == 1'b0, "R7 rx ready low", lnk_rx_ready, 0);
    set_hold(1'b0);
    close_step();
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule